// File: doc/BRIEF.md
# Lease-Timed Private Data Cache

A small direct-mapped data cache that sits between one core and a shared second-level store. It keeps itself coherent without any coherence messages. Every resident line holds an expiry time. The cache compares that time against a counter that the whole chip shares. Once the counter has reached a line's expiry, the line counts as gone. No other agent ever has to tell the cache to drop it, and the cache never sends or receives invalidations, acknowledgements or sharer bookkeeping.

A load that finds a live line answers from the cache. A load that finds an expired, invalid or mismatched line sends a read to the shared level and waits. The response carries the word and a 32-bit expiry, and both are written into the line. Stores always go straight through to the shared level. A store that hits a live line also refreshes the local copy. A store never allocates a line. Only one fill can be outstanding at a time, so the core sees its ready signal drop until the fill comes back.

Top module: `lease_l1`

## Requirements
- R1: After reset, coreReady is 1, coreRspValid and l2ReqValid are 0, and every line is invalid, so the first load to any address misses.
- R2: A load accepted (coreValid and coreReady at a rising edge) hits when the line at index coreAddr[3:0] is valid, its stored tag equals coreAddr[15:4], and its expiry is later than globalTime. The cycle after acceptance then shows coreRspValid=1 with the stored word, and no L2 request is made.
- R3: A load that is not a hit makes l2ReqValid=1, l2ReqWe=0 and l2ReqAddr equal to the load address in the cycle after acceptance. A line whose expiry equals the current counter value is a miss.
- R4: While a fill is outstanding, an l2RspValid pulse leads in the next cycle to coreRspValid=1 with coreRspData equal to l2RspData and to coreReady=1. The line is installed with the returned word, the tag and l2RspLease as its expiry.
- R5: From the cycle after a load miss is accepted until the cycle after its response, coreReady is 0 and no further request is accepted. An l2RspValid pulse arriving with no fill outstanding is ignored.
- R6: Every accepted store produces, in the next cycle, l2ReqValid=1, l2ReqWe=1 and the store's address and data on l2ReqAddr and l2ReqWdata. It gives no core response.
- R7: A store that hits a live line updates that line's word. A store that misses leaves the cache unchanged, so a later load to that address misses.
- R8: Expiry is judged by the sign of (expiry minus globalTime) taken modulo 2^32, so a line stays live across a counter rollover. For example, expiry 0x00000010 is still live at counter 0xFFFFFFF0.
- R9: l2ReqValid is raised only in the cycle after an accepted load miss or store. The cache issues no other traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| globalTime | input | 32 | Chip-wide synchronized counter |
| coreValid | input | 1 | Core request present |
| coreWe | input | 1 | 1 = store, 0 = load |
| coreAddr | input | 16 | Word address |
| coreWdata | input | 32 | Store data |
| coreReady | output | 1 | Cache can accept a request this cycle |
| coreRspValid | output | 1 | Load data valid |
| coreRspData | output | 32 | Load data |
| l2ReqValid | output | 1 | Request to shared level |
| l2ReqWe | output | 1 | 1 = write-through, 0 = fill read |
| l2ReqAddr | output | 16 | Request address |
| l2ReqWdata | output | 32 | Write-through data |
| l2RspValid | input | 1 | Fill response present |
| l2RspData | input | 32 | Fill word |
| l2RspLease | input | 32 | Expiry time for the filled line |

## Verification
Suppose a line's expiry, tag or valid bit is held wrongly. The next load to that index shows it at once: a stale word appears one cycle after acceptance where a fill request should have gone out, or an extra fill request appears where a hit was due. Both are visible at the ports in the cycle after the load. A wrong fill state shows as coreReady stuck low, or as a second request accepted while a fill is pending, one cycle after the miss. A wrong wrap comparison only shows when the counter crosses a rollover or sits exactly on an expiry value, so those points are driven on purpose.

// File: rtl/lease_l1_pkg.sv
package lease_l1_pkg;
  typedef struct packed {
    logic loadHit;
    logic loadMiss;
    logic storeAcc;
    logic fillDone;
  } l1_strobe_t;
endpackage

// File: rtl/lease_l1_expiry.sv
module lease_l1_expiry #(
  parameter int TS_W = 32
) (
  input  logic [TS_W-1:0] lease,
  input  logic [TS_W-1:0] now,
  output logic            live
);
  logic [TS_W-1:0] delta;
  // live when lease - now is a positive value in modular arithmetic
  assign delta = lease - now;
  assign live  = !delta[TS_W-1] && (delta != '0);
endmodule

// File: rtl/lease_l1_ctrl.sv
module lease_l1_ctrl
  import lease_l1_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreValid,
  input  logic       coreWe,
  input  logic       lineLive,
  input  logic       l2RspValid,
  output logic       coreReady,
  output l1_strobe_t strb
);
  typedef enum logic {ST_IDLE, ST_FILL} st_t;
  st_t stateQ;
  logic accept;

  assign coreReady = (stateQ == ST_IDLE);
  assign accept    = coreValid && coreReady;

  always_comb begin
    strb.loadHit  = accept && !coreWe && lineLive;
    strb.loadMiss = accept && !coreWe && !lineLive;
    strb.storeAcc = accept && coreWe;
    strb.fillDone = (stateQ == ST_FILL) && l2RspValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else if (strb.loadMiss) stateQ <= ST_FILL;
    else if (strb.fillDone) stateQ <= ST_IDLE;
  end
endmodule

// File: rtl/lease_l1_dp.sv
module lease_l1_dp
  import lease_l1_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   globalTime,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] l2RspData,
  input  logic [TS_W-1:0]   l2RspLease,
  input  l1_strobe_t        strb,
  output logic              lineLive,
  output logic              coreRspValid,
  output logic [DATA_W-1:0] coreRspData,
  output logic              l2ReqValid,
  output logic              l2ReqWe,
  output logic [ADDR_W-1:0] l2ReqAddr,
  output logic [DATA_W-1:0] l2ReqWdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]   validQ;
  logic [TAG_W-1:0]  tagQ  [SETS];
  logic [DATA_W-1:0] dataQ [SETS];
  logic [TS_W-1:0]   tsQ   [SETS];

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [ADDR_W-1:0] pendAddrQ;
  logic [IDX_W-1:0]  pendIdx;
  logic [TAG_W-1:0]  pendTag;
  logic              notExpired;

  assign reqIdx  = coreAddr[IDX_W-1:0];
  assign reqTag  = coreAddr[ADDR_W-1:IDX_W];
  assign pendIdx = pendAddrQ[IDX_W-1:0];
  assign pendTag = pendAddrQ[ADDR_W-1:IDX_W];

  lease_l1_expiry #(.TS_W(TS_W)) u_expiry (
    .lease(tsQ[reqIdx]),
    .now  (globalTime),
    .live (notExpired)
  );

  assign lineLive = validQ[reqIdx] && (tagQ[reqIdx] == reqTag) && notExpired;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic selFill;
    logic selStore;
    assign selFill  = strb.fillDone && (pendIdx == IDX_W'(s));
    assign selStore = strb.storeAcc && lineLive && (reqIdx == IDX_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ[s] <= 1'b0;
      else if (selFill) validQ[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (selFill) begin
        tagQ[s]  <= pendTag;
        tsQ[s]   <= l2RspLease;
        dataQ[s] <= l2RspData;
      end else if (selStore) begin
        dataQ[s] <= coreWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddrQ    <= '0;
      coreRspValid <= 1'b0;
      coreRspData  <= '0;
      l2ReqValid   <= 1'b0;
      l2ReqWe      <= 1'b0;
      l2ReqAddr    <= '0;
      l2ReqWdata   <= '0;
    end else begin
      coreRspValid <= strb.loadHit || strb.fillDone;
      if (strb.loadHit)       coreRspData <= dataQ[reqIdx];
      else if (strb.fillDone) coreRspData <= l2RspData;
      l2ReqValid <= strb.loadMiss || strb.storeAcc;
      if (strb.loadMiss || strb.storeAcc) begin
        l2ReqWe    <= strb.storeAcc;
        l2ReqAddr  <= coreAddr;
        l2ReqWdata <= coreWdata;
      end
      if (strb.loadMiss) pendAddrQ <= coreAddr;
    end
  end
endmodule

// File: rtl/lease_l1.sv
module lease_l1
  import lease_l1_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   globalTime,
  input  logic              coreValid,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic              coreReady,
  output logic              coreRspValid,
  output logic [DATA_W-1:0] coreRspData,
  output logic              l2ReqValid,
  output logic              l2ReqWe,
  output logic [ADDR_W-1:0] l2ReqAddr,
  output logic [DATA_W-1:0] l2ReqWdata,
  input  logic              l2RspValid,
  input  logic [DATA_W-1:0] l2RspData,
  input  logic [TS_W-1:0]   l2RspLease
);
  l1_strobe_t strb;
  logic lineLive;

  lease_l1_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .coreValid (coreValid),
    .coreWe    (coreWe),
    .lineLive  (lineLive),
    .l2RspValid(l2RspValid),
    .coreReady (coreReady),
    .strb      (strb)
  );

  lease_l1_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W), .SETS(SETS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .globalTime  (globalTime),
    .coreAddr    (coreAddr),
    .coreWdata   (coreWdata),
    .l2RspData   (l2RspData),
    .l2RspLease  (l2RspLease),
    .strb        (strb),
    .lineLive    (lineLive),
    .coreRspValid(coreRspValid),
    .coreRspData (coreRspData),
    .l2ReqValid  (l2ReqValid),
    .l2ReqWe     (l2ReqWe),
    .l2ReqAddr   (l2ReqAddr),
    .l2ReqWdata  (l2ReqWdata)
  );
endmodule

// File: rtl/lease_l1_chk.sv
module lease_l1_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              coreValid,
  input logic              coreWe,
  input logic [ADDR_W-1:0] coreAddr,
  input logic [DATA_W-1:0] coreWdata,
  input logic              coreReady,
  input logic              coreRspValid,
  input logic [DATA_W-1:0] coreRspData,
  input logic              l2ReqValid,
  input logic              l2ReqWe,
  input logic [ADDR_W-1:0] l2ReqAddr,
  input logic [DATA_W-1:0] l2ReqWdata,
  input logic              l2RspValid,
  input logic [DATA_W-1:0] l2RspData
);
  // R6
  store_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && coreReady && coreWe) |=> (l2ReqValid && l2ReqWe &&
      l2ReqAddr == $past(coreAddr) && l2ReqWdata == $past(coreWdata)));

  // R6
  store_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && coreReady && coreWe) |=> !coreRspValid);

  // R9
  no_unsolicited_chk: assert property (@(posedge clk) disable iff (!rstN)
    l2ReqValid |-> $past(coreValid && coreReady));

  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l2ReqValid && !l2ReqWe) |-> !coreReady);

  // R4
  fill_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!coreReady && l2RspValid) |=> (coreRspValid && coreReady &&
      coreRspData == $past(l2RspData)));
endmodule

bind lease_l1 lease_l1_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .coreValid(coreValid), .coreWe(coreWe),
  .coreAddr(coreAddr), .coreWdata(coreWdata), .coreReady(coreReady),
  .coreRspValid(coreRspValid), .coreRspData(coreRspData),
  .l2ReqValid(l2ReqValid), .l2ReqWe(l2ReqWe), .l2ReqAddr(l2ReqAddr),
  .l2ReqWdata(l2ReqWdata), .l2RspValid(l2RspValid), .l2RspData(l2RspData)
);

// File: tb/lease_l1_bench.sv
module lease_l1_bench;
  localparam int AW = 16, DW = 32, TW = 32, SETS = 16, IW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic [TW-1:0] globalTime = '0;
  logic setReq = 1'b0;
  logic [TW-1:0] setVal = '0;
  logic coreValid, coreWe;
  logic [AW-1:0] coreAddr;
  logic [DW-1:0] coreWdata;
  logic coreReady, coreRspValid;
  logic [DW-1:0] coreRspData;
  logic l2ReqValid, l2ReqWe;
  logic [AW-1:0] l2ReqAddr;
  logic [DW-1:0] l2ReqWdata;
  logic l2RspValid;
  logic [DW-1:0] l2RspData;
  logic [TW-1:0] l2RspLease;

  always @(posedge clk) globalTime <= setReq ? setVal : globalTime + 1;

  lease_l1 u_lease_l1 (
    .clk(clk), .rstN(rstN), .globalTime(globalTime),
    .coreValid(coreValid), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreReady(coreReady),
    .coreRspValid(coreRspValid), .coreRspData(coreRspData),
    .l2ReqValid(l2ReqValid), .l2ReqWe(l2ReqWe), .l2ReqAddr(l2ReqAddr),
    .l2ReqWdata(l2ReqWdata), .l2RspValid(l2RspValid),
    .l2RspData(l2RspData), .l2RspLease(l2RspLease)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic          mValid [SETS];
  logic [AW-IW-1:0] mTag [SETS];
  logic [DW-1:0] mData [SETS];
  logic [TW-1:0] mTs   [SETS];
  logic [DW-1:0] mem   [64];
  logic [DW-1:0] lastRsp;
  bit lastMiss;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mHit(input logic [AW-1:0] a, input logic [TW-1:0] now);
    int i = int'(a[IW-1:0]);
    logic [TW-1:0] d = mTs[i] - now;
    return mValid[i] && mTag[i] == a[AW-1:IW] && !d[TW-1] && d != 0;
  endfunction

  task automatic setTime(input logic [TW-1:0] v);
    setReq = 1'b1; setVal = v;
    @(negedge clk);
    setReq = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(l2ReqValid === 1'b0, "R9 quiet while idle", l2ReqValid, 0);
    end
  endtask

  task automatic doLoad(input logic [AW-1:0] a, input int delay,
                        input bit useOv, input logic [TW-1:0] leaseOv);
    int i = int'(a[IW-1:0]);
    bit hit;
    logic [TW-1:0] lease;
    hit = mHit(a, globalTime);
    coreValid = 1'b1; coreWe = 1'b0; coreAddr = a;
    @(negedge clk);
    coreValid = 1'b0;
    lastMiss = !hit;
    if (hit) begin
      lastRsp = coreRspData;
      check(coreRspValid === 1'b1 && coreRspData === mData[i], "R2 hit data", coreRspData, mData[i]);
      check(l2ReqValid === 1'b0, "R2 hit makes no request", l2ReqValid, 0);
    end else begin
      check(l2ReqValid === 1'b1 && l2ReqWe === 1'b0 && l2ReqAddr === a, "R3 fill request", l2ReqAddr, a);
      check(coreReady === 1'b0 && coreRspValid === 1'b0, "R5 stall on miss", coreReady, 0);
      for (int k = 0; k < delay; k++) begin
        coreValid = 1'b1; coreWe = k[0]; coreAddr = a ^ 16'h0010;
        @(negedge clk);
        check(l2ReqValid === 1'b0 && coreReady === 1'b0, "R5 second request held", l2ReqValid, 0);
      end
      coreValid = 1'b0;
      lease = useOv ? leaseOv : globalTime + 1 + ($urandom % 60);
      l2RspValid = 1'b1; l2RspData = mem[a[5:0]]; l2RspLease = lease;
      @(negedge clk);
      l2RspValid = 1'b0;
      lastRsp = coreRspData;
      check(coreRspValid === 1'b1 && coreRspData === mem[a[5:0]], "R4 fill data", coreRspData, mem[a[5:0]]);
      check(coreReady === 1'b1, "R4 ready restored", coreReady, 1);
      mValid[i] = 1'b1; mTag[i] = a[AW-1:IW]; mData[i] = mem[a[5:0]]; mTs[i] = lease;
    end
  endtask

  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int i = int'(a[IW-1:0]);
    bit hit;
    hit = mHit(a, globalTime);
    coreValid = 1'b1; coreWe = 1'b1; coreAddr = a; coreWdata = d;
    @(negedge clk);
    coreValid = 1'b0;
    check(l2ReqValid === 1'b1 && l2ReqWe === 1'b1 && l2ReqAddr === a && l2ReqWdata === d,
          "R6 write-through", {l2ReqAddr, l2ReqWdata}, {a, d});
    check(coreRspValid === 1'b0, "R6 no store response", coreRspValid, 0);
    mem[a[5:0]] = d;
    if (hit) mData[i] = d;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 64; k++) mem[k] = (k * 32'h01010101) ^ 32'hA5000000;
    for (int k = 0; k < SETS; k++) begin
      mValid[k] = 1'b0; mTag[k] = '0; mData[k] = '0; mTs[k] = '0;
    end
    rstN = 1'b0; coreValid = 1'b0; coreWe = 1'b0; coreAddr = '0; coreWdata = '0;
    l2RspValid = 1'b0; l2RspData = '0; l2RspLease = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(coreReady === 1'b1 && coreRspValid === 1'b0 && l2ReqValid === 1'b0,
          "R1 reset outputs", {coreReady, coreRspValid, l2ReqValid}, 3'b100);

    doLoad(16'h0003, 2, 1'b1, globalTime + 2000);
    check(lastMiss == 1, "R1 first load misses", lastMiss, 1);
    doLoad(16'h0003, 0, 1'b0, '0);
    check(lastMiss == 0, "R2 live line hits", lastMiss, 0);

    doStore(16'h0003, 32'hCAFE0003);
    doLoad(16'h0003, 0, 1'b0, '0);
    check(lastMiss == 0 && lastRsp === 32'hCAFE0003, "R7 store hit refreshes line", lastRsp, 32'hCAFE0003);

    doStore(16'h0028, 32'h0BAD0028);
    doLoad(16'h0028, 1, 1'b0, '0);
    check(lastMiss == 1, "R7 store miss does not allocate", lastMiss, 1);

    l2RspValid = 1'b1; l2RspData = 32'hDEADDEAD; l2RspLease = globalTime + 5000;
    @(negedge clk);
    l2RspValid = 1'b0;
    check(coreRspValid === 1'b0, "R5 stray response ignored", coreRspValid, 0);
    doLoad(16'h0003, 0, 1'b0, '0);
    check(lastMiss == 0 && lastRsp === 32'hCAFE0003, "R5 stray response left line intact", lastRsp, 32'hCAFE0003);

    doLoad(16'h0007, 0, 1'b1, globalTime + 6);
    idle(10);
    doLoad(16'h0007, 0, 1'b0, '0);
    check(lastMiss == 1, "R3 lease runs out without messages", lastMiss, 1);

    setTime(32'hFFFF_FFF0);
    doLoad(16'h0005, 0, 1'b1, 32'h0000_0010);
    doLoad(16'h0005, 0, 1'b0, '0);
    check(lastMiss == 0, "R8 live across rollover", lastMiss, 0);
    setTime(32'h0000_000F);
    doLoad(16'h0005, 0, 1'b0, '0);
    check(lastMiss == 0, "R8 live one tick before expiry", lastMiss, 0);
    setTime(32'h0000_0010);
    doLoad(16'h0005, 0, 1'b0, '0);
    check(lastMiss == 1, "R3 expiry equal to counter misses", lastMiss, 1);

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 64);
      if (($urandom % 10) < 6) doLoad(a, int'($urandom % 4), 1'b0, '0);
      else doStore(a, $urandom);
      if (($urandom % 8) == 0) idle(int'($urandom % 5) + 1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule